// File: doc/BRIEF.md
# Reset-Strap Mode Select and Port Power-Disable Encoder

This block decides at hardware reset which kind of link controller, if any, sits next to a three-port cable interface. While reset is held, it samples a clock pin that doubles as a strap together with a generation-select pin. From these two pins it latches one of three operating modes: no link controller (power-management operation), a legacy link, or a new-generation link. The latched mode is exported to the datapath and does not change again until the next hardware reset.

In power-management operation no link controller uses the 8-bit data bus. The block therefore drives the bus with status of its own: one cable-power-disable flag per port, plus a flag that is set only when every port is disabled. Each port's flag is worked out from that port's encoded link state and from three register bits: disable, hard-disable and sleep-enable. In the two link modes the bus is held at zero, because the normal link datapath owns it.

Top module: `pwr_strap_enc`

## Requirements
- R1: With `strap_clk`=1 and `gen_sel`=1 sampled during reset, the block latches no-link mode: `mode_out`=0 and `mgmt_mode`=1. Code 3 never appears on `mode_out`, and `mgmt_mode` is 1 exactly when `mode_out` is 0.
- R2: With `gen_sel`=0 sampled during reset, the block latches legacy mode (`mode_out`=1, `mgmt_mode`=0), whatever the value of `strap_clk`.
- R3: With `strap_clk`=0 and `gen_sel`=1 sampled during reset, the block latches new-generation mode (`mode_out`=2, `mgmt_mode`=0).
- R4: Once reset is released, `mode_out` and `mgmt_mode` hold their values. Changes on `strap_clk` or `gen_sel` have no effect on them.
- R5: While `rst_n` is low, `pwr_bus` reads zero from the first clock edge onward.
- R6: In no-link mode, bit i of `pwr_bus` (i = 0, 1, 2) is the power-disable flag of port i, registered one clock after its inputs change. Port i's state is taken from `port_state[3i+2:3i]`.
- R7: A port's flag is 1 when its state code is disconnected (0), asleep (1), DS-suspended (3) or DS-disabled (4). The unused codes 6 and 7 also give 1.
- R8: A port in state dc-connected (2) or active (5) has a flag of 0, unless the condition in R9 holds.
- R9: The flag is 1 in any state when the port's disable bit is set together with its hard-disable bit or its sleep-enable bit. A hard-disable or sleep-enable bit without the disable bit has no effect, and so does the disable bit on its own.
- R10: In no-link mode, `pwr_bus[6]` is the AND of `pwr_bus[2:0]`.
- R11: `pwr_bus` bits 3, 4, 5 and 7 are always 0.
- R12: In legacy or new-generation mode, `pwr_bus` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Hardware reset, active low, synchronous; straps are sampled while low |
| strap_clk | input | 1 | Link clock pin, read as a mode strap during reset |
| gen_sel | input | 1 | Generation-select pin, read as a mode strap during reset |
| port_state | input | 9 | Encoded state of each port, 3 bits per port, port 0 in the lowest bits |
| port_dis | input | 3 | Per-port disable register bit |
| port_hard_dis | input | 3 | Per-port hard-disable register bit |
| port_sleep_en | input | 3 | Per-port sleep-enable register bit |
| pwr_bus | output | 8 | Power-status data bus |
| mode_out | output | 2 | Latched mode: 0 no-link, 1 legacy, 2 new-generation |
| mgmt_mode | output | 1 | High when the latched mode is no-link |

## Verification
The assertions check on every cycle after reset the properties that hold at all times:
- the mode is stable and legal;
- the reserved bits are zero;
- the all-ports bit matches the port bits;
- each port bit follows the evaluated flag from one cycle earlier;
- the bus stays silent outside power-management operation.

Some behaviour only the bench's scenarios can show: which mode each strap combination selects, and the truth table that maps states and register bits to a flag. The bench also shows that toggling the straps after reset leaves the mode unchanged, and that the bus is cleared while reset is held.

// File: rtl/pwrstrap_pkg.sv
package pwrstrap_pkg;

  typedef enum logic [1:0] {
    MODE_NOLINK = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_NEWGEN = 2'd2
  } link_mode_e;

  localparam logic [2:0] ST_DISCONN = 3'd0;
  localparam logic [2:0] ST_ASLEEP  = 3'd1;
  localparam logic [2:0] ST_DCCONN  = 3'd2;
  localparam logic [2:0] ST_DS_SUSP = 3'd3;
  localparam logic [2:0] ST_DS_DIS  = 3'd4;
  localparam logic [2:0] ST_ACTIVE  = 3'd5;

  // Mode chosen from the two strap pins.
  function automatic link_mode_e decode_mode(input logic strap, input logic gen);
    if (!gen)
      return MODE_LEGACY;
    else if (strap)
      return MODE_NOLINK;
    else
      return MODE_NEWGEN;
  endfunction

  // Cable power is kept on only for dc-connected or active ports that
  // are not forced off by the register bits.
  function automatic logic port_off(input logic [2:0] st, input logic dis,
                                    input logic hard, input logic sleep);
    logic forced;
    forced = dis & (hard | sleep);
    if (st == ST_DCCONN || st == ST_ACTIVE)
      return forced;
    else
      return 1'b1;
  endfunction

endpackage

// File: rtl/strap_mode_latch.sv
module strap_mode_latch
  import pwrstrap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_i,
  input  logic       gen_i,
  output link_mode_e mode_o
);

  link_mode_e mode_q;

  // Follows the straps while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= decode_mode(strap_i, gen_i);
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/port_off_eval.sv
module port_off_eval
  import pwrstrap_pkg::*;
(
  input  logic [2:0] state_i,
  input  logic       dis_i,
  input  logic       hard_i,
  input  logic       sleep_i,
  output logic       off_o
);

  always_comb off_o = port_off(state_i, dis_i, hard_i, sleep_i);

endmodule

// File: rtl/pwr_bus_pack.sv
module pwr_bus_pack #(
  parameter int NPORT   = 3,
  parameter int BUS_W   = 8,
  parameter int ALL_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [NPORT-1:0] flags_i,
  output logic [BUS_W-1:0] bus_o
);

  logic [BUS_W-1:0] next_bus;

  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    if (b < NPORT) begin : g_port
      assign next_bus[b] = flags_i[b];
    end else if (b == ALL_BIT) begin : g_all
      assign next_bus[b] = &flags_i;
    end else begin : g_rsvd
      assign next_bus[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_o <= '0;
    else if (en_i)
      bus_o <= next_bus;
    else
      bus_o <= '0;
  end

endmodule

// File: rtl/pwr_strap_enc.sv
module pwr_strap_enc
  import pwrstrap_pkg::*;
#(
  parameter int NPORT   = 3,
  parameter int BUS_W   = 8,
  parameter int ALL_BIT = 6,
  localparam int ST_W   = 3 * NPORT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_clk,
  input  logic             gen_sel,
  input  logic [ST_W-1:0]  port_state,
  input  logic [NPORT-1:0] port_dis,
  input  logic [NPORT-1:0] port_hard_dis,
  input  logic [NPORT-1:0] port_sleep_en,
  output logic [BUS_W-1:0] pwr_bus,
  output logic [1:0]       mode_out,
  output logic             mgmt_mode
);

  link_mode_e       mode_w;
  logic [NPORT-1:0] port_flags;

  strap_mode_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_clk),
    .gen_i   (gen_sel),
    .mode_o  (mode_w)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    port_off_eval u_eval (
      .state_i (port_state[3*p +: 3]),
      .dis_i   (port_dis[p]),
      .hard_i  (port_hard_dis[p]),
      .sleep_i (port_sleep_en[p]),
      .off_o   (port_flags[p])
    );
  end

  assign mode_out  = mode_w;
  assign mgmt_mode = (mode_w == MODE_NOLINK);

  pwr_bus_pack #(
    .NPORT   (NPORT),
    .BUS_W   (BUS_W),
    .ALL_BIT (ALL_BIT)
  ) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (mgmt_mode),
    .flags_i (port_flags),
    .bus_o   (pwr_bus)
  );

endmodule

// File: rtl/pwrstrap_chk.sv
module pwrstrap_chk #(
  parameter int NPORT   = 3,
  parameter int BUS_W   = 8,
  parameter int ALL_BIT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] pwr_bus,
  input logic [1:0]       mode_out,
  input logic             mgmt_mode,
  input logic [NPORT-1:0] port_flags
);

  function automatic logic [BUS_W-1:0] rsvd_mask();
    logic [BUS_W-1:0] m;
    for (int b = 0; b < BUS_W; b++)
      m[b] = (b >= NPORT) && (b != ALL_BIT);
    return m;
  endfunction

  localparam logic [BUS_W-1:0] RSVD = rsvd_mask();

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(mode_out) && $stable(mgmt_mode)));

  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out != 2'd3) && (mgmt_mode == (mode_out == 2'd0)));

  assert_quiet_link_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out != 2'd0) |-> (pwr_bus == '0));

  assert_rsvd_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_bus & RSVD) == '0);

  assert_all_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_mode |-> (pwr_bus[ALL_BIT] == &pwr_bus[NPORT-1:0]));

  assert_port_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_mode && $past(rst_n)) |-> (pwr_bus[NPORT-1:0] == $past(port_flags)));

endmodule

bind pwr_strap_enc pwrstrap_chk #(
  .NPORT   (NPORT),
  .BUS_W   (BUS_W),
  .ALL_BIT (ALL_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_bus    (pwr_bus),
  .mode_out   (mode_out),
  .mgmt_mode  (mgmt_mode),
  .port_flags (port_flags)
);

// File: tb/pwr_strap_enc_test.sv
module pwr_strap_enc_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       strap_clk = 1'b0;
  logic       gen_sel = 1'b0;
  logic [8:0] port_state = '0;
  logic [2:0] port_dis = '0;
  logic [2:0] port_hard_dis = '0;
  logic [2:0] port_sleep_en = '0;
  logic [7:0] pwr_bus;
  logic [1:0] mode_out;
  logic       mgmt_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_strap_enc uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_clk     (strap_clk),
    .gen_sel       (gen_sel),
    .port_state    (port_state),
    .port_dis      (port_dis),
    .port_hard_dis (port_hard_dis),
    .port_sleep_en (port_sleep_en),
    .pwr_bus       (pwr_bus),
    .mode_out      (mode_out),
    .mgmt_mode     (mgmt_mode)
  );

  // Fields: states {p2,p1,p0} | dis | hard | sleep | expected bus
  localparam int NV = 9;
  localparam logic [25:0] VECS [NV] = '{
    {3'd5, 3'd5, 3'd5, 3'b000, 3'b000, 3'b000, 8'h00},  // R8 all active
    {3'd2, 3'd5, 3'd0, 3'b000, 3'b000, 3'b000, 8'h01},  // R7 R8 disconnected p0
    {3'd1, 3'd3, 3'd4, 3'b000, 3'b000, 3'b000, 8'h47},  // R7 R10 asleep/DS states
    {3'd2, 3'd2, 3'd2, 3'b111, 3'b000, 3'b000, 8'h00},  // R9 disable alone
    {3'd5, 3'd5, 3'd5, 3'b011, 3'b001, 3'b010, 8'h03},  // R9 hard and sleep forced
    {3'd5, 3'd5, 3'd5, 3'b000, 3'b111, 3'b111, 8'h00},  // R9 no disable bit
    {3'd7, 3'd6, 3'd2, 3'b000, 3'b000, 3'b000, 8'h06},  // R7 unused codes
    {3'd5, 3'd5, 3'd5, 3'b111, 3'b100, 3'b011, 8'h47},  // R9 R10 all forced
    {3'd3, 3'd2, 3'd5, 3'b000, 3'b000, 3'b000, 8'h04}   // R7 R11 DS-suspended p2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ports(input logic [8:0] st, input logic [2:0] d,
                           input logic [2:0] h, input logic [2:0] s);
    port_state = st;
    port_dis = d;
    port_hard_dis = h;
    port_sleep_en = s;
  endtask

  // Reset with the given straps, then flip the straps after release.
  task automatic reset_with(input logic strap, input logic gen);
    @(negedge clk);
    rst_n = 1'b0;
    strap_clk = strap;
    gen_sel = gen;
    set_ports({3'd1, 3'd1, 3'd1}, 3'b000, 3'b000, 3'b000);
    repeat (3) @(negedge clk);
    check("R5 bus cleared in reset", 32'(pwr_bus), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    strap_clk = ~strap;
    gen_sel = ~gen;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #3 rst_n = 1'b0;

    // No-link mode and the flag table
    reset_with(1'b1, 1'b1);
    check("R1 mode no-link", 32'(mode_out), 32'd0);
    check("R1 mgmt flag", 32'(mgmt_mode), 32'd1);
    check("R4 mode held after strap flip", 32'(mode_out), 32'd0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_ports(VECS[i][25:17], VECS[i][16:14], VECS[i][13:11], VECS[i][10:8]);
      @(negedge clk);
      check($sformatf("R6 R7 R8 R9 R10 R11 vector %0d", i), 32'(pwr_bus), 32'(VECS[i][7:0]));
    end

    // Legacy via gen low, strap low
    reset_with(1'b0, 1'b0);
    check("R2 legacy strap low", 32'(mode_out), 32'd1);
    check("R2 mgmt flag low", 32'(mgmt_mode), 32'd0);
    check("R12 bus silent in legacy", 32'(pwr_bus), 32'h0);

    // Legacy via gen low, strap high
    reset_with(1'b1, 1'b0);
    check("R2 legacy strap high", 32'(mode_out), 32'd1);
    check("R4 legacy held", 32'(mgmt_mode), 32'd0);

    // New-generation mode
    reset_with(1'b0, 1'b1);
    check("R3 new-generation mode", 32'(mode_out), 32'd2);
    check("R12 bus silent in new-gen", 32'(pwr_bus), 32'h0);
    check("R4 new-gen held after flip", 32'(mode_out), 32'd2);

    // Back to no-link: bus resumes
    reset_with(1'b1, 1'b1);
    check("R1 no-link again", 32'(mode_out), 32'd0);
    check("R10 all asleep sets all-ports bit", 32'(pwr_bus), 32'h47);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule